// File: doc/BRIEF.md
# Serial Configuration Shift Chain

This block loads a chip's configuration over a four-wire serial link. The host pulls chip select low and clocks bits in on the data-in line. Each bit enters the bottom of a long shift chain. The top stage of the chain drives the data-out line, so the host reads back the previous chain contents while it writes new ones. The active configuration outputs come from a separate row of level-sensitive holding latches. These latches open only when chip select is released, so shifting never disturbs the running configuration. A separate enable output tells the board when the data-out line is being driven, which lets several such devices share one host.

The serial inputs are asynchronous to the block clock. They pass through synchronizers, and an edge detector turns their changes into strobes for the datapath. The block also handles reset fan-out:
- A channel reset clears only the coarse timebase counter.
- A chip reset clears the counter, the chain and the holding row. It also drops any transfer in progress and raises an idle request for the downstream state machines.

The block clock must be at least 2·(SYNC_STAGES+2) times faster than the serial clock on each serial clock phase.

Top module: `cfg_shift_chain`

## Requirements
- R1: While chipRst is high, cfgOut, spiMiso, spiMisoEn and coarseTime are all zero, and the shift chain is cleared.
- R2: While selected, each rising spiSclk samples spiMosi into chain bit 0 and moves every chain bit one place toward bit CHAIN_LEN-1.
- R3: spiMiso takes chain bit CHAIN_LEN-1 when chip select falls and after every falling spiSclk. A CHAIN_LEN-bit transfer therefore returns the previous chain contents, most significant bit first.
- R4: cfgOut does not change while a transfer is in progress.
- R5: On the rising edge of spiCsN, cfgOut takes the chain contents with bit positions kept. In a CHAIN_LEN-bit transfer, the first bit sent ends up in cfgOut[CHAIN_LEN-1].
- R6: A transfer of any bit count commits whatever the chain then holds: old bits shifted up by the count, new bits below. No length check is made.
- R7: spiSclk edges while spiCsN is high shift nothing and change no output.
- R8: spiMisoEn is high only from the detected falling edge of spiCsN until its detected rising edge.
- R9: coarseTime increments by one every clock and wraps modulo 2^TB_W.
- R10: chanRst clears coarseTime on the next clock. It leaves cfgOut, the chain and any commit unaffected.
- R11: chipRst raises fsmIdleReq one clock later. It also abandons a transfer in progress: later spiSclk edges and the following spiCsN rise shift and commit nothing.
- R12: fsmIdleReq stays low whenever chipRst was low on the previous clock, including during chanRst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| chipRst | input | 1 | Synchronous chip reset, active high |
| chanRst | input | 1 | Synchronous timebase-only reset, active high |
| spiSclk | input | 1 | Serial clock from the host, asynchronous |
| spiCsN | input | 1 | Chip select, active low, asynchronous |
| spiMosi | input | 1 | Serial data from the host |
| spiMiso | output | 1 | Serial readback data to the host |
| spiMisoEn | output | 1 | High while spiMiso should drive the shared line |
| cfgOut | output | CHAIN_LEN | Active configuration from the holding latches |
| coarseTime | output | TB_W | Coarse timebase counter |
| fsmIdleReq | output | 1 | Registered request for downstream state machines to go idle |

## Verification
The holding-row commit and the channel reset can land in the same clock. The bench raises chanRst in the same cycle that releases chip select and holds it across the whole commit window. It then checks that cfgOut equals the newly shifted pattern and that coarseTime restarted from zero. A second collision is a chip reset in the middle of a transfer. The bench keeps clocking after the reset, then releases chip select, and expects cfgOut to remain cleared and the next readback to return all zeros.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;

  typedef enum logic {
    LINK_IDLE   = 1'b0,
    LINK_ACTIVE = 1'b1
  } linkState_t;

  // Strobes from control to datapath, one clock wide, registered.
  typedef struct packed {
    logic present;   // load readback bit from chain top
    logic shift;     // advance chain by one bit
    logic shiftBit;  // bit entering chain bottom
    logic commit;    // open holding row
  } chainStb_t;

endpackage

// File: rtl/cfg_chain_sync.sv
module cfg_chain_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stage;

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= RST_VAL;
    else     stage[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[g] <= RST_VAL;
      else     stage[g] <= stage[g-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/cfg_chain_ctrl.sv
module cfg_chain_ctrl
  import cfg_chain_pkg::*;
(
  input  logic      clk,
  input  logic      chipRst,
  input  logic      sclkSync,
  input  logic      csNSync,
  input  logic      mosiSync,
  output chainStb_t stb,
  output logic      selected
);

  linkState_t state, stateNext;
  chainStb_t  stbNext;
  logic       sclkPrev, csNPrev;
  logic       sclkRise, sclkFall, csFall, csRise;

  assign sclkRise = sclkSync & ~sclkPrev;
  assign sclkFall = ~sclkSync & sclkPrev;
  assign csFall   = ~csNSync & csNPrev;
  assign csRise   = csNSync & ~csNPrev;

  always_comb begin
    stateNext        = state;
    stbNext          = '0;
    stbNext.shiftBit = mosiSync;
    unique case (state)
      LINK_IDLE: begin
        if (csFall) begin
          stateNext       = LINK_ACTIVE;
          stbNext.present = 1'b1;
        end
      end
      LINK_ACTIVE: begin
        if (csRise) begin
          stateNext      = LINK_IDLE;
          stbNext.commit = 1'b1;
        end else if (sclkRise) begin
          stbNext.shift = 1'b1;
        end else if (sclkFall) begin
          stbNext.present = 1'b1;
        end
      end
      default: stateNext = LINK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (chipRst) begin
      state    <= LINK_IDLE;
      stb      <= '0;
      sclkPrev <= 1'b0;
      csNPrev  <= 1'b0;
    end else begin
      state    <= stateNext;
      stb      <= stbNext;
      sclkPrev <= sclkSync;
      csNPrev  <= csNSync;
    end
  end

  assign selected = (state == LINK_ACTIVE);

endmodule

// File: rtl/cfg_chain_path.sv
module cfg_chain_path
  import cfg_chain_pkg::*;
#(
  parameter int CHAIN_LEN = 64
) (
  input  logic                 clk,
  input  logic                 chipRst,
  input  chainStb_t            stb,
  output logic                 miso,
  output logic [CHAIN_LEN-1:0] holdRow
);

  localparam int TOP = CHAIN_LEN - 1;

  logic [CHAIN_LEN-1:0] chain;

  always_ff @(posedge clk) begin
    if (chipRst)        chain <= '0;
    else if (stb.shift) chain <= {chain[TOP-1:0], stb.shiftBit};
  end

  always_ff @(posedge clk) begin
    if (chipRst)          miso <= 1'b0;
    else if (stb.present) miso <= chain[TOP];
  end

  // Holding row: opens for one clock after a commit strobe; the chain is
  // quiet during that window because shift and commit are exclusive.
  always_latch begin
    if (chipRst)         holdRow = '0;
    else if (stb.commit) holdRow = chain;
  end

endmodule

// File: rtl/cfg_chain_resets.sv
module cfg_chain_resets #(
  parameter int TB_W = 16
) (
  input  logic            clk,
  input  logic            chipRst,
  input  logic            chanRst,
  output logic [TB_W-1:0] coarseTime,
  output logic            fsmIdleReq
);

  always_ff @(posedge clk) begin
    if (chipRst || chanRst) coarseTime <= '0;
    else                    coarseTime <= coarseTime + 1'b1;
  end

  always_ff @(posedge clk) begin
    fsmIdleReq <= chipRst;
  end

endmodule

// File: rtl/cfg_shift_chain.sv
module cfg_shift_chain
  import cfg_chain_pkg::*;
#(
  parameter int CHAIN_LEN   = 64,
  parameter int TB_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 chipRst,
  input  logic                 chanRst,
  input  logic                 spiSclk,
  input  logic                 spiCsN,
  input  logic                 spiMosi,
  output logic                 spiMiso,
  output logic                 spiMisoEn,
  output logic [CHAIN_LEN-1:0] cfgOut,
  output logic [TB_W-1:0]      coarseTime,
  output logic                 fsmIdleReq
);

  logic      sclkSync, csNSync, mosiSync;
  chainStb_t ctrlStb;

  cfg_chain_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_syncSclk (
    .clk(clk), .rst(chipRst), .d(spiSclk), .q(sclkSync));
  // Select resets to "asserted" so a low select at reset release is no edge.
  cfg_chain_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_syncCs (
    .clk(clk), .rst(chipRst), .d(spiCsN), .q(csNSync));
  cfg_chain_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_syncMosi (
    .clk(clk), .rst(chipRst), .d(spiMosi), .q(mosiSync));

  cfg_chain_ctrl u_ctrl (
    .clk(clk), .chipRst(chipRst), .sclkSync(sclkSync), .csNSync(csNSync),
    .mosiSync(mosiSync), .stb(ctrlStb), .selected(spiMisoEn));

  cfg_chain_path #(.CHAIN_LEN(CHAIN_LEN)) u_path (
    .clk(clk), .chipRst(chipRst), .stb(ctrlStb), .miso(spiMiso),
    .holdRow(cfgOut));

  cfg_chain_resets #(.TB_W(TB_W)) u_resets (
    .clk(clk), .chipRst(chipRst), .chanRst(chanRst),
    .coarseTime(coarseTime), .fsmIdleReq(fsmIdleReq));

endmodule

// File: rtl/cfg_shift_chain_chk.sv
module cfg_shift_chain_chk
  import cfg_chain_pkg::*;
#(
  parameter int CHAIN_LEN = 64,
  parameter int TB_W      = 16
) (
  input logic                 clk,
  input logic                 chipRst,
  input logic                 chanRst,
  input logic                 spiMisoEn,
  input logic [CHAIN_LEN-1:0] cfgOut,
  input logic [TB_W-1:0]      coarseTime,
  input logic                 fsmIdleReq,
  input chainStb_t            ctrlStb
);

  assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (chipRst)
    $onehot0({ctrlStb.present, ctrlStb.shift, ctrlStb.commit}));

  assert_cfg_frozen_R4: assert property (@(posedge clk) disable iff (chipRst)
    (spiMisoEn && $past(spiMisoEn)) |-> $stable(cfgOut));

  assert_cfg_only_on_commit_R5: assert property (@(posedge clk) disable iff (chipRst)
    !ctrlStb.commit |-> $stable(cfgOut));

  assert_shift_when_selected_R7: assert property (@(posedge clk) disable iff (chipRst)
    ctrlStb.shift |-> spiMisoEn);

  assert_tb_step_R9: assert property (@(posedge clk) disable iff (chipRst)
    ($past(!chipRst) && $past(!chanRst)) |-> coarseTime == TB_W'($past(coarseTime) + 1'b1));

  assert_chan_clear_R10: assert property (@(posedge clk) disable iff (chipRst)
    chanRst |=> coarseTime == '0);

  assert_idle_req_R11: assert property (@(posedge clk)
    chipRst |=> fsmIdleReq);

  assert_idle_quiet_R12: assert property (@(posedge clk)
    !chipRst |=> !fsmIdleReq);

endmodule

bind cfg_shift_chain cfg_shift_chain_chk #(.CHAIN_LEN(CHAIN_LEN), .TB_W(TB_W)) u_chk (
  .clk(clk), .chipRst(chipRst), .chanRst(chanRst), .spiMisoEn(spiMisoEn),
  .cfgOut(cfgOut), .coarseTime(coarseTime), .fsmIdleReq(fsmIdleReq),
  .ctrlStb(ctrlStb));

// File: tb/cfg_shift_chain_tb.sv
module cfg_shift_chain_tb;

  localparam int LEN  = 64;
  localparam int TBW  = 16;
  localparam int HALF = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic chipRst, chanRst, spiSclk, spiCsN, spiMosi;
  logic spiMiso, spiMisoEn, fsmIdleReq;
  logic [LEN-1:0] cfgOut;
  logic [TBW-1:0] coarseTime;

  cfg_shift_chain #(.CHAIN_LEN(LEN), .TB_W(TBW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .chipRst(chipRst), .chanRst(chanRst), .spiSclk(spiSclk),
    .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso),
    .spiMisoEn(spiMisoEn), .cfgOut(cfgOut), .coarseTime(coarseTime),
    .fsmIdleReq(fsmIdleReq));

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  logic [LEN-1:0] model;   // expected chain
  logic [LEN-1:0] active;  // expected cfgOut

  task automatic check(input string req, input logic [LEN-1:0] act, input logic [LEN-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [2*LEN-1:0] randWide();
    logic [2*LEN-1:0] v;
    for (int i = 0; i < 2*LEN/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic csLow();
    spiCsN = 1'b0;
    waitN(HALF);
    check("R8 misoEn while selected", spiMisoEn, 1);
  endtask

  task automatic csHigh(input string req);
    spiCsN = 1'b1;
    waitN(HALF + 2);
    active = model;
    check(req, cfgOut, active);
    check("R8 misoEn after release", spiMisoEn, 0);
  endtask

  task automatic xferBit(input logic b, input string req);
    spiMosi = b;
    check({req, " R3 readback bit"}, spiMiso, model[LEN-1]);
    check("R4 cfg frozen", cfgOut, active);
    spiSclk = 1'b1;
    model = {model[LEN-2:0], b};
    waitN(HALF);
    spiSclk = 1'b0;
    waitN(HALF);
  endtask

  task automatic xfer(input int n, input logic [2*LEN-1:0] data, input string req);
    csLow();
    for (int k = n - 1; k >= 0; k--) xferBit(data[k], req);
    csHigh({req, " R5 commit"});
  endtask

  initial begin
    waitN(190000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    if (!done) $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    chipRst = 1'b1; chanRst = 1'b0;
    spiSclk = 1'b0; spiCsN = 1'b1; spiMosi = 1'b0;
    waitN(3);
    check("R1 cfgOut in reset", cfgOut, 0);
    check("R1 miso in reset", spiMiso, 0);
    check("R1 misoEn in reset", spiMisoEn, 0);
    check("R1 coarse in reset", coarseTime, 0);
    check("R11 idleReq during reset", fsmIdleReq, 1);
    chipRst = 1'b0;
    waitN(2);
    check("R12 idleReq after release", fsmIdleReq, 0);
    model = '0; active = '0;

    // Directed full transfers
    xfer(LEN, {LEN'(0), {LEN{1'b1}}}, "R2 ones");
    xfer(LEN, {LEN'(0), 1'b1, {(LEN-2){1'b0}}, 1'b1}, "R2 ends");
    check("R5 first bit at top", cfgOut[LEN-1], 1);

    // Random full transfers
    for (int i = 0; i < 6; i++) xfer(LEN, randWide(), "R3 random");

    // Short and long transfers
    xfer(5, randWide(), "R6 short");
    xfer(LEN + 7, randWide(), "R6 long");

    // Clocking while deselected
    for (int i = 0; i < 10; i++) begin
      spiMosi = i[0];
      spiSclk = 1'b1; waitN(HALF);
      spiSclk = 1'b0; waitN(HALF);
    end
    check("R7 cfg unchanged when deselected", cfgOut, active);
    check("R7 misoEn low when deselected", spiMisoEn, 0);
    xfer(LEN, randWide(), "R7 readback after idle clocks");

    // Timebase counting and channel reset
    begin
      logic [TBW-1:0] t0;
      t0 = coarseTime;
      waitN(37);
      check("R9 count step", coarseTime, LEN'(TBW'(t0 + 37)));
    end
    chanRst = 1'b1;
    waitN(1);
    chanRst = 1'b0;
    check("R10 coarse cleared", coarseTime, 0);
    check("R12 idleReq quiet on chanRst", fsmIdleReq, 0);
    waitN(1 << TBW);
    check("R9 wrap", coarseTime, 0);
    check("R10 cfg untouched", cfgOut, active);
    xfer(LEN, randWide(), "R10 chain untouched");

    // Commit colliding with channel reset
    begin
      logic [2*LEN-1:0] d;
      d = randWide();
      csLow();
      for (int k = LEN - 1; k >= 0; k--) xferBit(d[k], "R10 collide");
      spiCsN = 1'b1;
      chanRst = 1'b1;
      waitN(HALF + 2);
      chanRst = 1'b0;
      waitN(1);
      active = model;
      check("R10 commit survives chanRst", cfgOut, active);
      check("R10 coarse restarted", coarseTime, 1);
    end

    // Chip reset in the middle of a transfer
    csLow();
    for (int k = 0; k < 10; k++) xferBit(1'($urandom), "R11 pre");
    chipRst = 1'b1;
    waitN(2);
    check("R11 idleReq", fsmIdleReq, 1);
    check("R1 cfg cleared", cfgOut, 0);
    check("R1 misoEn cleared", spiMisoEn, 0);
    chipRst = 1'b0;
    model = '0; active = '0;
    for (int k = 0; k < 5; k++) begin
      spiMosi = 1'b1;
      spiSclk = 1'b1; waitN(HALF);
      spiSclk = 1'b0; waitN(HALF);
    end
    spiCsN = 1'b1;
    waitN(HALF + 2);
    check("R11 no commit after abandon", cfgOut, 0);
    check("R11 misoEn stays low", spiMisoEn, 0);
    xfer(LEN, randWide(), "R11 chain empty");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule